// File: doc/BRIEF.md
# Non-blocking Cache Miss Tracker

This block keeps the bookkeeping for data-cache misses that are still waiting for the next cache level. While they wait, the cache keeps serving later requests, including hits. A missing load presents its cache-line address and its load-buffer index. If no entry holds that line, the tracker claims a free fill-buffer entry and sends one request for the line to the next level. If an entry already holds that line, the load is added to that entry's waiter set. No extra request is sent and no extra slot is used.

The number of distinct lines in flight is capped at `ENTRIES`. When every slot holds a line and a load asks for yet another line, the load is refused and recorded as parked, and a sticky full flag goes up. When the next level returns the critical chunk for a slot, the tracker frees that slot. It also raises a wake-up carrying the mask of every load waiting on the line, together with every parked load, so that all of them can be re-dispatched. Every miss request, whether accepted or refused, also produces a mark one cycle later that tells the write-back stage that this load's data is invalid.

Top module: `line_miss_tracker`

## Requirements
- R1: After reset no slot is valid and `full`, `parked`, `nl_req_valid`, `wake_valid` and `kill_valid` are all 0.
- R2: A request whose line matches no valid slot, while some slot is free, is accepted with `req_merge`=0 and `req_slot` equal to the lowest-numbered free slot. In the following cycle `nl_req_valid`=1, with `nl_req_line` and `nl_req_slot` carrying that line and slot.
- R3: A request whose line matches a valid slot that is not being filled in the same cycle is accepted with `req_merge`=1 and `req_slot` equal to that slot. No next-level request follows, and the slot count does not change. This holds even when all slots are in use.
- R4: At most `ENTRIES` distinct lines are held at once. A request for a new line when every slot is valid and none is being filled gets `req_accept`=0.
- R5: A refused request sets bit `req_ldid` of `parked` and raises `full` from the next cycle. `full` stays 1 until a fill of a valid slot.
- R6: A fill of a valid slot frees it. In the next cycle `wake_valid`=1, `wake_line` is the slot's line, and `wake_mask` is the OR of one bit per load accepted into that slot and the `parked` bits. `parked` and `full` clear in that cycle.
- R7: In a cycle with both a fill and a request, the fill frees its slot first. The freed slot may be claimed by the request. A request for the line being filled does not merge; it claims a fresh slot.
- R8: Every request (`req_valid`=1) gives `kill_valid`=1 and `kill_ldid`=`req_ldid` in the next cycle.
- R9: A fill naming an invalid slot has no effect: no wake-up, and the slots, `parked` and `full` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Missing load presents a request |
| req_line | input | LINE_W | Cache-line address of the request |
| req_ldid | input | LDID_W | Load-buffer index of the requesting load |
| req_accept | output | 1 | Request allocated or merged (same cycle) |
| req_merge | output | 1 | Request joined an existing slot |
| req_slot | output | SLOT_W | Slot used by an accepted request |
| fill_valid | input | 1 | Critical chunk returned |
| fill_slot | input | SLOT_W | Slot whose chunk returned |
| nl_req_valid | output | 1 | Request to next cache level |
| nl_req_line | output | LINE_W | Line requested from next level |
| nl_req_slot | output | SLOT_W | Fill-buffer slot of that request |
| wake_valid | output | 1 | Wake-up pulse |
| wake_line | output | LINE_W | Line that returned |
| wake_mask | output | 2**LDID_W | Loads to re-dispatch |
| kill_valid | output | 1 | Write-back data of a missing load is invalid |
| kill_ldid | output | LDID_W | Load whose data is invalid |
| full | output | 1 | A request was refused and no slot has freed since |
| parked | output | 2**LDID_W | Loads refused and awaiting retry |

## Verification
The hardest case to reach is a fill landing in the same cycle as a request. The outcome depends on whether the request names the filling line, another pending line, or a new line while the tracker is full. The stimulus first fills all slots with directed requests. It then applies the fill together with each of these three kinds of request. After that, random traffic draws lines from a pool only slightly larger than the slot count, which makes merges, refusals and coincident fills frequent.

// File: rtl/line_miss_tracker.sv
module line_miss_tracker #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int LDID_W  = 3,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int NLOADS = 1 << LDID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic [LDID_W-1:0] req_ldid,
  output logic              req_accept,
  output logic              req_merge,
  output logic [SLOT_W-1:0] req_slot,
  input  logic              fill_valid,
  input  logic [SLOT_W-1:0] fill_slot,
  output logic              nl_req_valid,
  output logic [LINE_W-1:0] nl_req_line,
  output logic [SLOT_W-1:0] nl_req_slot,
  output logic              wake_valid,
  output logic [LINE_W-1:0] wake_line,
  output logic [NLOADS-1:0] wake_mask,
  output logic              kill_valid,
  output logic [LDID_W-1:0] kill_ldid,
  output logic              full,
  output logic [NLOADS-1:0] parked
);

  logic [ENTRIES-1:0] v_q;
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [NLOADS-1:0]  wait_q [ENTRIES];

  logic               freeing;
  logic [ENTRIES-1:0] hit, open;
  logic               any_hit, any_open;
  logic [SLOT_W-1:0]  hit_idx, open_idx;
  logic [NLOADS-1:0]  ld_bit;
  logic               refused;

  assign freeing = fill_valid && v_q[fill_slot];
  assign ld_bit  = NLOADS'(1) << req_ldid;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      hit[i]  = v_q[i] && (line_q[i] == req_line) && !(freeing && fill_slot == SLOT_W'(i));
      open[i] = !v_q[i] || (freeing && fill_slot == SLOT_W'(i));
    end
  end

  always_comb begin
    hit_idx  = '0;
    open_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i])  hit_idx  = SLOT_W'(i);
      if (open[i]) open_idx = SLOT_W'(i);
    end
  end

  assign any_hit    = |hit;
  assign any_open   = |open;
  assign req_merge  = req_valid && any_hit;
  assign req_accept = req_valid && (any_hit || any_open);
  assign req_slot   = any_hit ? hit_idx : open_idx;
  assign refused    = req_valid && !req_accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q          <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        line_q[i] <= '0;
        wait_q[i] <= '0;
      end
      nl_req_valid <= 1'b0;
      nl_req_line  <= '0;
      nl_req_slot  <= '0;
      wake_valid   <= 1'b0;
      wake_line    <= '0;
      wake_mask    <= '0;
      kill_valid   <= 1'b0;
      kill_ldid    <= '0;
      full         <= 1'b0;
      parked       <= '0;
    end else begin
      wake_valid <= freeing;
      if (freeing) begin
        wake_line         <= line_q[fill_slot];
        wake_mask         <= wait_q[fill_slot] | parked;
        v_q[fill_slot]    <= 1'b0;
        wait_q[fill_slot] <= '0;
        parked            <= '0;
        full              <= 1'b0;
      end

      nl_req_valid <= req_accept && !req_merge;
      if (req_accept && !req_merge) begin
        v_q[open_idx]    <= 1'b1;
        line_q[open_idx] <= req_line;
        wait_q[open_idx] <= ld_bit;
        nl_req_line      <= req_line;
        nl_req_slot      <= open_idx;
      end
      if (req_merge)
        wait_q[hit_idx] <= wait_q[hit_idx] | ld_bit;

      if (refused) begin
        parked[req_ldid] <= 1'b1;
        full             <= 1'b1;
      end

      kill_valid <= req_valid;
      if (req_valid) kill_ldid <= req_ldid;
    end
  end

  p_new_line_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nl_req_valid |-> $past(req_valid && req_accept && !req_merge));

  p_merge_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_merge) |=> !nl_req_valid);

  p_refuse_only_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_accept) |-> (&v_q) && !fill_valid);

  p_full_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !fill_valid) |=> full);

  p_wake_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> $past(fill_valid));

  p_kill_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (kill_valid && kill_ldid == $past(req_ldid)));

endmodule

// File: tb/line_miss_tracker_test.sv
module line_miss_tracker_test;
  localparam int E  = 4;
  localparam int LW = 26;
  localparam int IW = 3;
  localparam int SW = 2;
  localparam int NL = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, fill_valid = 0;
  logic [LW-1:0] req_line = '0;
  logic [IW-1:0] req_ldid = '0;
  logic [SW-1:0] fill_slot = '0;
  logic req_accept, req_merge, nl_req_valid, wake_valid, kill_valid, full;
  logic [SW-1:0] req_slot, nl_req_slot;
  logic [LW-1:0] nl_req_line, wake_line;
  logic [NL-1:0] wake_mask, parked;
  logic [IW-1:0] kill_ldid;

  always #4 clk = ~clk;

  line_miss_tracker #(.ENTRIES(E), .LINE_W(LW), .LDID_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .req_ldid(req_ldid), .req_accept(req_accept), .req_merge(req_merge),
    .req_slot(req_slot), .fill_valid(fill_valid), .fill_slot(fill_slot),
    .nl_req_valid(nl_req_valid), .nl_req_line(nl_req_line), .nl_req_slot(nl_req_slot),
    .wake_valid(wake_valid), .wake_line(wake_line), .wake_mask(wake_mask),
    .kill_valid(kill_valid), .kill_ldid(kill_ldid), .full(full), .parked(parked));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit            m_v [E];
  logic [LW-1:0] m_line [E];
  logic [NL-1:0] m_wait [E];
  logic [NL-1:0] m_parked = '0;
  bit            m_full = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int find_hit(input logic [LW-1:0] ln, input bit fr, input int fs);
    for (int i = 0; i < E; i++)
      if (m_v[i] && m_line[i] == ln && !(fr && fs == i)) return i;
    return -1;
  endfunction

  function automatic int find_open(input bit fr, input int fs);
    for (int i = 0; i < E; i++)
      if (!m_v[i] || (fr && fs == i)) return i;
    return -1;
  endfunction

  task automatic step(input bit rv, input logic [LW-1:0] ln, input logic [IW-1:0] id,
                      input bit fv, input logic [SW-1:0] fs);
    bit fr;
    int h, o, slot;
    bit acc, mrg;
    logic [NL-1:0] e_wmask;
    logic [LW-1:0] e_wline;
    req_valid = rv; req_line = ln; req_ldid = id; fill_valid = fv; fill_slot = fs;
    #1;
    fr  = fv && m_v[fs];
    h   = find_hit(ln, fr, int'(fs));
    o   = find_open(fr, int'(fs));
    acc = rv && (h >= 0 || o >= 0);
    mrg = rv && h >= 0;
    slot = (h >= 0) ? h : o;
    chk(acc ? (mrg ? "R3" : "R2") : "R4", "req_accept", req_accept, acc);
    if (rv) chk(fr ? "R7" : "R3", "req_merge", req_merge, mrg);
    if (acc) chk(fr ? "R7" : "R2", "req_slot", req_slot, slot);
    e_wmask = '0; e_wline = '0;
    if (fr) begin
      e_wmask = m_wait[fs] | m_parked;
      e_wline = m_line[fs];
      m_v[fs] = 0; m_wait[fs] = '0; m_parked = '0; m_full = 0;
    end
    if (acc && !mrg) begin
      m_v[slot] = 1; m_line[slot] = ln; m_wait[slot] = NL'(1) << id;
    end else if (mrg) begin
      m_wait[slot] = m_wait[slot] | (NL'(1) << id);
    end else if (rv) begin
      m_parked[id] = 1'b1; m_full = 1;
    end
    @(posedge clk); #1;
    chk("R2", "nl_req_valid", nl_req_valid, acc && !mrg);
    if (acc && !mrg) begin
      chk("R2", "nl_req_line", nl_req_line, ln);
      chk("R2", "nl_req_slot", nl_req_slot, slot);
    end
    chk(fv && !fr ? "R9" : "R6", "wake_valid", wake_valid, fr);
    if (fr) begin
      chk("R6", "wake_mask", wake_mask, e_wmask);
      chk("R6", "wake_line", wake_line, e_wline);
    end
    chk("R5", "full", full, m_full);
    chk("R5", "parked", parked, m_parked);
    chk("R8", "kill_valid", kill_valid, rv);
    if (rv) chk("R8", "kill_ldid", kill_ldid, id);
    @(negedge clk);
  endtask

  function automatic logic [LW-1:0] pool(input int k);
    return LW'(32'h100 + k * 32'h40);
  endfunction

  initial begin
    for (int i = 0; i < E; i++) begin m_v[i] = 0; m_line[i] = '0; m_wait[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "full", full, 0);
    chk("R1", "parked", parked, 0);
    chk("R1", "nl_req_valid", nl_req_valid, 0);
    chk("R1", "wake_valid", wake_valid, 0);
    chk("R1", "kill_valid", kill_valid, 0);
    rst_n = 1;
    @(negedge clk);
    // R9: fill to an empty slot does nothing
    step(0, '0, 0, 1, 2);
    // R2: fill all slots
    for (int k = 0; k < E; k++) step(1, pool(k), IW'(k), 0, 0);
    // R3: merge while full
    step(1, pool(1), 5, 0, 0);
    // R4/R5: refuse new line
    step(1, pool(7), 6, 0, 0);
    step(1, pool(8), 7, 0, 0);
    step(0, '0, 0, 0, 0);
    // R6/R7: fill slot 1 with new line same cycle takes freed slot
    step(1, pool(9), 4, 1, 1);
    // R7: fill slot 0 while requesting its line -> fresh slot
    step(1, pool(0), 2, 1, 0);
    // R7: fill slot 2 and merge into slot 3 together
    step(1, pool(3), 1, 1, 2);
    for (int s = 0; s < E; s++) step(0, '0, 0, 1, SW'(s));
    void'($urandom(32'd20240611));
    for (int c = 0; c < 3000; c++) begin
      bit rv, fv;
      rv = ($urandom % 100) < 70;
      fv = ($urandom % 100) < 30;
      step(rv, pool($urandom % 6), IW'($urandom), fv, SW'($urandom));
    end
    for (int s = 0; s < E; s++) step(0, '0, 0, 1, SW'(s));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule